// File: doc/BRIEF.md
# Stride-Adaptive Convolution Window Feeder

The block keeps a 3x3 window of channel-vector pixels in registers and hands it to a 3x3 convolution kernel. The kernel takes one window every `SLOT` cycles (nine by default). New data comes from a line buffer that holds three feature-map rows. The line buffer returns one column of three vertically stacked pixels per read, in the same cycle as the read.

When the stride is 1, consecutive windows share two columns, so the block fetches one column per slot. When the stride is 2, they share only one column, so the block fetches two columns in the same slot. Because of this, the next window is still ready at the slot boundary and the kernel never waits.

Each output row begins with a start pulse. The block then primes the window with three columns, streams windows across the row, and ends with a one-cycle done pulse. While the kernel holds its ready input low, the window is frozen and no column reads are issued.

Top module: `stride_window_feeder`

## Requirements
- R1: After reset, `win_valid_o`, `lb_rd_o` and `row_done_o` are all low, and they stay low until a row is started.
- R2: When `row_start_i` is high in the idle state, the block latches `stride2_i` (0 selects stride 1, 1 selects stride 2). It then reads columns 0, 1 and 2 on the next three cycles, provided `win_ready_i` is high. The first window is valid in the cycle after the third read, which is four cycles after the start was sampled.
- R3: Pixel row r of line-buffer data sits at `lb_col_i[r*PIX_W +: PIX_W]`. In the window, field `win_o[(c*3+r)*PIX_W +: PIX_W]` holds pixel row r of window column c, where c=0 is the oldest (leftmost) column.
- R4: With stride 1, each accepted window is followed by exactly one column read. The next window is the previous one shifted by one column, and it is valid exactly `SLOT` cycles after the previous acceptance.
- R5: With stride 2, each accepted window is followed by two column reads. The next window is shifted by two columns, and it is still valid exactly `SLOT` cycles after the previous acceptance.
- R6: Read addresses on `lb_col_o` start at 0, rise by one per read, and never reach `IN_COLS`. A row yields (IN_COLS-3)/stride+1 windows, using integer division.
- R7: While `win_valid_o` is high and `win_ready_i` is low, the window contents and `win_valid_o` hold, and no read is issued.
- R8: Column reads are issued only in cycles with `win_ready_i` high. Reads held back between windows resume when ready returns. The window is still valid `SLOT` cycles after acceptance if the reads finish in time.
- R9: `row_done_o` is a one-cycle pulse in the cycle after the last window of a row is accepted. The block then stays idle, with no reads and no valid window, until the next start.
- R10: Changes on `stride2_i` and pulses on `row_start_i` while a row is in progress have no effect on the read addresses, the window timing or the window contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| row_start_i | input | 1 | Starts one output row; honoured only when idle |
| stride2_i | input | 1 | Stride select: 0 = stride 1, 1 = stride 2 |
| lb_rd_o | output | 1 | Line-buffer column read strobe |
| lb_col_o | output | $clog2(IN_COLS+1) | Column index being read |
| lb_col_i | input | 3*PIX_W | Column data, three stacked pixels, same cycle as read |
| win_valid_o | output | 1 | Window valid toward the kernel |
| win_ready_i | input | 1 | Kernel accepts the window; low also suspends reads |
| win_o | output | 9*PIX_W | 3x3 window of pixels |
| row_done_o | output | 1 | One-cycle pulse after the last window of a row |

## Verification
The bench counts cycles from the edge that samples the start pulse. It expects the first window four cycles later and every later window exactly `SLOT` cycles after the handshake that took the one before it. It expects the done pulse one cycle after the final handshake. Line-buffer data is driven in the same cycle as the read address, so each read is checked against the expected column in the cycle it appears. The count of reads between two windows is checked when the next window first becomes valid. Inputs change on the falling edge and all outputs are sampled just after it, so every expected value refers to the state left by the preceding rising edge.

// File: rtl/swf_pkg.sv
package swf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_GAP   = 2'd2,
    ST_VALID = 2'd3
  } swf_state_e;

  localparam int unsigned WIN_ROWS = 3;
  localparam int unsigned WIN_COLS = 3;
endpackage

// File: rtl/swf_slot_timer.sv
module swf_slot_timer #(
  parameter int unsigned SLOT = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned LAST = SLOT - 2;
  localparam int unsigned CW   = $clog2(SLOT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (clear_i)                       cnt_q <= '0;
    else if (run_i && cnt_q != CW'(LAST))   cnt_q <= cnt_q + 1'b1;
  end

  // Gap cycles after a handshake number 0..LAST; the window returns on the next cycle.
  assign expired_o = (cnt_q == CW'(LAST));
endmodule

// File: rtl/swf_col_window.sv
module swf_col_window
  import swf_pkg::*;
#(
  parameter int unsigned PIX_W = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             shift_i,
  input  logic [WIN_ROWS*PIX_W-1:0]          col_i,
  output logic [WIN_COLS*WIN_ROWS*PIX_W-1:0] win_o
);
  localparam int unsigned COL_W = WIN_ROWS * PIX_W;

  logic [COL_W-1:0] col_q [WIN_COLS];

  for (genvar c = 0; c < WIN_COLS; c++) begin : g_col
    logic [COL_W-1:0] src;
    if (c == WIN_COLS - 1) begin : g_new
      assign src = col_i;
    end else begin : g_old
      assign src = col_q[c+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      col_q[c] <= '0;
      else if (shift_i) col_q[c] <= src;
    end

    assign win_o[c*COL_W +: COL_W] = col_q[c];
  end
endmodule

// File: rtl/swf_fetch_ctrl.sv
module swf_fetch_ctrl
  import swf_pkg::*;
#(
  parameter int unsigned IN_COLS = 9,
  localparam int unsigned CW     = $clog2(IN_COLS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          row_start_i,
  input  logic          stride2_i,
  input  logic          win_ready_i,
  input  logic          slot_expired_i,
  output logic          lb_rd_o,
  output logic [CW-1:0] lb_col_o,
  output logic          slot_clear_o,
  output logic          slot_run_o,
  output logic          win_valid_o,
  output logic          row_done_o
);
  swf_state_e    state_q, state_d;
  logic [CW-1:0] col_ptr_q;
  logic [1:0]    rem_q;
  logic          stride2_q;
  logic          row_done_q;
  logic [CW:0]   step_w;
  logic          last_win;
  logic          accept;
  logic          rd;

  assign step_w   = stride2_q ? (CW+1)'(2) : (CW+1)'(1);
  assign last_win = ({1'b0, col_ptr_q} + step_w) > (CW+1)'(IN_COLS);
  assign accept   = (state_q == ST_VALID) && win_ready_i;

  always_comb begin
    state_d = state_q;
    rd      = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (row_start_i) state_d = ST_PRIME;
      ST_PRIME: begin
        rd = win_ready_i;
        if (rd && rem_q == 2'd1) state_d = ST_VALID;
      end
      ST_GAP: begin
        rd = win_ready_i && (rem_q != 2'd0);
        if (slot_expired_i && (rem_q == 2'd0 || (rem_q == 2'd1 && rd)))
          state_d = ST_VALID;
      end
      ST_VALID: if (win_ready_i) state_d = last_win ? ST_IDLE : ST_GAP;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      col_ptr_q  <= '0;
      rem_q      <= '0;
      stride2_q  <= 1'b0;
      row_done_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      row_done_q <= accept && last_win;
      if (state_q == ST_IDLE && row_start_i) begin
        col_ptr_q <= '0;
        rem_q     <= 2'd3;
        stride2_q <= stride2_i;
      end else if (rd) begin
        col_ptr_q <= col_ptr_q + 1'b1;
        rem_q     <= rem_q - 2'd1;
      end else if (accept && !last_win) begin
        rem_q <= stride2_q ? 2'd2 : 2'd1;
      end
    end
  end

  assign lb_rd_o      = rd;
  assign lb_col_o     = col_ptr_q;
  assign slot_clear_o = accept;
  assign slot_run_o   = (state_q == ST_GAP);
  assign win_valid_o  = (state_q == ST_VALID);
  assign row_done_o   = row_done_q;

  // R9
  row_done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_done_o |=> !row_done_o);

  // R6
  rd_addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_rd_o |-> (lb_col_o < CW'(IN_COLS)));

  // R4
  valid_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_valid_o) |-> ($past(slot_expired_i) || $past(lb_rd_o)));
endmodule

// File: rtl/stride_window_feeder.sv
module stride_window_feeder
  import swf_pkg::*;
#(
  parameter int unsigned PIX_W   = 32,
  parameter int unsigned IN_COLS = 9,
  parameter int unsigned SLOT    = 9,
  localparam int unsigned CW     = $clog2(IN_COLS + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             row_start_i,
  input  logic                             stride2_i,
  output logic                             lb_rd_o,
  output logic [CW-1:0]                    lb_col_o,
  input  logic [WIN_ROWS*PIX_W-1:0]          lb_col_i,
  output logic                             win_valid_o,
  input  logic                             win_ready_i,
  output logic [WIN_COLS*WIN_ROWS*PIX_W-1:0] win_o,
  output logic                             row_done_o
);
  logic slot_clear, slot_run, slot_expired, rd;

  swf_slot_timer #(.SLOT(SLOT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (slot_clear),
    .run_i     (slot_run),
    .expired_o (slot_expired)
  );

  swf_fetch_ctrl #(.IN_COLS(IN_COLS)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .row_start_i    (row_start_i),
    .stride2_i      (stride2_i),
    .win_ready_i    (win_ready_i),
    .slot_expired_i (slot_expired),
    .lb_rd_o        (rd),
    .lb_col_o       (lb_col_o),
    .slot_clear_o   (slot_clear),
    .slot_run_o     (slot_run),
    .win_valid_o    (win_valid_o),
    .row_done_o     (row_done_o)
  );

  swf_col_window #(.PIX_W(PIX_W)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (rd),
    .col_i   (lb_col_i),
    .win_o   (win_o)
  );

  assign lb_rd_o = rd;

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && !win_ready_i) |=> (win_valid_o && $stable(win_o)));

  // R7
  no_rd_in_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> !lb_rd_o);

  // R4
  gap_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && win_ready_i) |=> !win_valid_o);
endmodule

// File: tb/stride_window_feeder_tb.sv
module stride_window_feeder_tb;
  localparam int PW       = 32;
  localparam int COLS     = 9;
  localparam int SLOT     = 9;
  localparam int CW       = $clog2(COLS + 1);
  localparam time CLK_PER = 10ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              row_start = 1'b0;
  logic              stride2 = 1'b0;
  logic              lb_rd;
  logic [CW-1:0]     lb_col;
  logic [3*PW-1:0]   lb_data;
  logic              win_valid;
  logic              win_ready = 1'b1;
  logic [9*PW-1:0]   win;
  logic              row_done;

  int checks = 0;
  int fails  = 0;
  int grp    = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  stride_window_feeder #(.PIX_W(PW), .IN_COLS(COLS), .SLOT(SLOT)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .row_start_i (row_start),
    .stride2_i   (stride2),
    .lb_rd_o     (lb_rd),
    .lb_col_o    (lb_col),
    .lb_col_i    (lb_data),
    .win_valid_o (win_valid),
    .win_ready_i (win_ready),
    .win_o       (win),
    .row_done_o  (row_done)
  );

  function automatic logic [PW-1:0] pix(int g, int r, int c);
    return {8'(g), 8'(r), 8'(c), 8'hA5};
  endfunction

  always_comb begin
    for (int r = 0; r < 3; r++) lb_data[r*PW +: PW] = pix(grp, r, int'(lb_col));
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One full row; optional stall while valid, stall in the gap, or mid-row disturbance.
  task automatic run_row(input bit s2, input int vs_win, input int vs_len,
                         input int gs_win, input int gs_len, input bit disturb);
    int step = s2 ? 2 : 1;
    int nwin = (COLS - 3) / step + 1;
    int k = 0, next_col = 0, cyc = 0, hs_cyc = -1, done_cyc = -1;
    int rd_gap = 0, vs_cnt = 0, gs_left = 0;
    bit seen = 1'b0, loop = 1'b1;
    logic [9*PW-1:0] held = '0;
    grp++;
    @(negedge clk);
    row_start = 1'b1; stride2 = s2; win_ready = 1'b1;
    @(negedge clk);
    row_start = 1'b0; cyc = 1;
    while (loop && cyc < 300) begin
      if (disturb && cyc == 6) begin row_start = 1'b1; stride2 = !s2; end
      if (disturb && cyc == 7) row_start = 1'b0;
      win_ready = 1'b1;
      if (gs_left > 0) begin win_ready = 1'b0; gs_left--; end
      if (win_valid && k == vs_win && vs_cnt < vs_len) begin win_ready = 1'b0; vs_cnt++; end
      #1;
      if (lb_rd) begin
        chk(int'(lb_col) == next_col, "R6 read address", lb_col, next_col);
        chk(win_ready, "R8 read only with ready", win_ready, 1);
        next_col++; rd_gap++;
      end
      if (win_valid) begin
        if (!seen) begin
          seen = 1'b1;
          if (k == 0) chk(cyc == 4, "R2 first window cycle", cyc, 4);
          else begin
            chk(cyc == hs_cyc + SLOT, s2 ? "R5 window period" : "R4 window period", cyc, hs_cyc + SLOT);
            chk(rd_gap == step, s2 ? "R5 reads per slot" : "R4 reads per slot", rd_gap, step);
          end
          for (int cc = 0; cc < 3; cc++)
            for (int r = 0; r < 3; r++)
              chk(win[(cc*3+r)*PW +: PW] == pix(grp, r, k*step + cc), "R3 window pixel",
                  win[(cc*3+r)*PW +: PW], pix(grp, r, k*step + cc));
        end else if (!win_ready || held != win) begin
          chk(win == held, "R7 window held", win[PW-1:0], held[PW-1:0]);
        end
        if (!win_ready) chk(!lb_rd, "R7 no read while stalled", lb_rd, 0);
        held = win;
        if (win_ready) begin
          hs_cyc = cyc; k++; rd_gap = 0; seen = 1'b0;
          if (k == nwin) done_cyc = cyc;
          if (k - 1 == gs_win) gs_left = gs_len;
        end
      end
      if (done_cyc >= 0 && cyc > done_cyc) begin
        chk(row_done == (cyc == done_cyc + 1), "R9 row done pulse", row_done, cyc == done_cyc + 1);
        chk(!win_valid && !lb_rd, "R9 idle after row", {win_valid, lb_rd}, 0);
        if (cyc == done_cyc + 4) loop = 1'b0;
      end else if (row_done) begin
        chk(1'b0, "R9 early row done", 1, 0);
      end
      @(negedge clk);
      cyc++;
    end
    chk(k == nwin, "R6 window count", k, nwin);
    chk(next_col == 3 + (nwin - 1) * step, "R6 column count", next_col, 3 + (nwin - 1) * step);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(!win_valid && !lb_rd && !row_done, "R1 reset outputs", {win_valid, lb_rd, row_done}, 0);
    end
  endtask

  task automatic t_stride1;       run_row(1'b0, -1, 0, -1, 0, 1'b0); endtask
  task automatic t_stride2;       run_row(1'b1, -1, 0, -1, 0, 1'b0); endtask
  task automatic t_stall_s1;      run_row(1'b0, 2, 5, 3, 2, 1'b0); endtask   // R7 R8
  task automatic t_stall_s2;      run_row(1'b1, 1, 4, 0, 3, 1'b0); endtask   // R7 R8
  task automatic t_disturb;       run_row(1'b0, -1, 0, -1, 0, 1'b1); endtask // R10
  task automatic t_idle_gap;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      chk(!win_valid && !lb_rd, "R9 idle until start", {win_valid, lb_rd}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_stride1();
    t_idle_gap();
    t_stride2();
    t_stall_s1();
    t_stall_s2();
    t_disturb();
    t_stride2();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule